// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block runs the interrupt entry and exit flows of a small 8-bit processor whose subroutine return addresses live in an on-chip stack. The core signals each instruction boundary. If an interrupt request is pending at that boundary and interrupts are not inhibited, the sequencer accepts it. On acceptance it sets the inhibit status bit and pushes the core's return address. It then raises interrupt acknowledge and operation request together and waits for the interrupting device to return an 8-bit vector on the data bus.

The vector is a displacement from address zero, so the handler is entered as a subroutine call relative to location zero. When vector bit 7 is set, the displaced address holds a two-byte pointer. The sequencer fetches that pointer with two memory reads, which lets the handler sit anywhere in the 32K space. A return-and-enable command pops the stack into the instruction address and clears the inhibit bit. A separate inhibit-clear command clears the bit without popping, which lets interrupts nest.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the stack pointer is 0, the inhibit bit is 0, the instruction address is 0, every stack entry is 0, and the operation request and interrupt acknowledge outputs are low.
- R2: A request is accepted only at a clock edge where `instr_done` and `irq_req` are both high, the inhibit bit is 0, the sequencer is idle and `ret_en` is low. A request without `instr_done`, or any request while inhibited, leaves the outputs, the stack pointer and the inhibit bit unchanged.
- R3: In the cycle after acceptance, `inhibit`, `int_ack` and `op_req` are all high.
- R4: `int_ack` stays high until a cycle in which `op_ack` is sampled high, and is low from the next cycle on.
- R5: With vector bit 7 = 0, the target is bits 6:0 taken as a signed value and sign-extended to 15 bits (0x7F gives 0x7FFF, 0x3F gives 0x003F). In the cycle after the vector's `op_ack`, `next_pc` equals the target, `branch_done` pulses high and `op_req` is low.
- R6: With vector bit 7 = 1, the same signed displacement gives a pointer address EA. The block then does two reads, with `op_req` and `ptr_rd` high and `int_ack` low: first at `mem_addr` = EA, which returns the high byte (bits 6:0 used), then at EA+1 wrapped to 15 bits, which returns the low byte. The target is {high[6:0], low}.
- R7: On acceptance the stack pointer increments modulo 8 and `ret_addr_in` is written at the new pointer. A ninth push without a pop overwrites the oldest entry.
- R8: In the idle state, `ret_en` loads `next_pc` from the entry at the pointer, decrements the pointer modulo 8, clears the inhibit bit and pulses `ret_done` in the next cycle. It takes precedence over an acceptance in the same cycle, so that request waits for the next `instr_done`.
- R9: In the idle state, `inh_clr` clears the inhibit bit without touching the stack, so a later request can be accepted on top of the one being served.
- R10: While a vector or pointer read is in progress, `ret_en`, `inh_clr` and `instr_done` have no effect: the stack pointer and the inhibit bit keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | Current instruction has finished (boundary) |
| irq_req | input | 1 | Interrupt request level |
| ret_addr_in | input | 15 | Return address to push on acceptance |
| ret_en | input | 1 | Return-and-enable command |
| inh_clr | input | 1 | Clear the inhibit bit |
| dbus_in | input | 8 | Data bus: vector or pointer bytes |
| op_ack | input | 1 | Operation acknowledge from the device or memory |
| op_req | output | 1 | Operation request (vector or pointer read active) |
| int_ack | output | 1 | Interrupt acknowledge (vector read active) |
| ptr_rd | output | 1 | Pointer byte read from memory active |
| mem_addr | output | 15 | Address of the pointer byte being read |
| inhibit | output | 1 | Interrupt inhibit status bit |
| stk_ptr | output | 3 | Return stack pointer |
| next_pc | output | 15 | Instruction address |
| branch_done | output | 1 | One-cycle pulse: handler target loaded |
| ret_done | output | 1 | One-cycle pulse: return address loaded |

## Verification
The case hardest to reach from the ports is return stack wrap-around. The inhibit bit normally prevents a second entry before a return, so a ninth push needs an `inh_clr` after every acceptance. The stimulus runs a directed chain of nine nested entries, each followed by `inh_clr`, and then nine returns. The model predicts that the last return gets the overwritten entry. Random rounds with randomized vectors and acknowledge delays also inject `ret_en` and `inh_clr` during pending handshakes, and they include pointers at the top of the address space whose second byte wraps to address zero.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

  localparam int ADDR_W  = 15;
  localparam int STK_DEP = 8;
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_VEC    = 2'd1,
    S_PTR_HI = 2'd2,
    S_PTR_LO = 2'd3
  } seq_state_t;

  // Signed 7-bit displacement from location zero, wrapped to the address width.
  function automatic logic [ADDR_W-1:0] rel_zero(input logic [BYTE_W-2:0] disp);
    rel_zero = {{(ADDR_W-BYTE_W+1){disp[BYTE_W-2]}}, disp};
  endfunction

  // Next byte address, wrapping inside the address space.
  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    addr_next = a + 1'b1;
  endfunction

endpackage

// File: rtl/ret_stack.sv
module ret_stack
  import irqseq_pkg::*;
#(
  parameter int DEPTH = STK_DEP,
  parameter int AW    = ADDR_W,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] wr_data,
  output logic [PW-1:0] sp,
  output logic [AW-1:0] top_data
);

  logic [AW-1:0] entry [DEPTH];
  logic [PW-1:0] sp_up;

  assign sp_up    = sp + 1'b1;
  assign top_data = entry[sp];

  always_ff @(posedge clk) begin
    if (!rst_n)    sp <= '0;
    else if (push) sp <= sp_up;
    else if (pop)  sp <= sp - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                          entry[i] <= '0;
      else if (push && sp_up == PW'(i))    entry[i] <= wr_data;
    end
  end

  p_push_incr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp == PW'($past(sp) + 1'b1));
  p_pop_decr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> sp == PW'($past(sp) - 1'b1));
  p_push_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top_data == $past(wr_data));
  p_no_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
  import irqseq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = BYTE_W,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_done,
  input  logic          irq_req,
  input  logic          ret_en,
  input  logic          inh_clr,
  input  logic [DW-1:0] dbus_in,
  input  logic          op_ack,
  input  logic [AW-1:0] ret_data,
  output logic          accept,
  output logic          pop,
  output logic          idle,
  output logic          inhibit,
  output logic          op_req,
  output logic          int_ack,
  output logic          ptr_rd,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] next_pc,
  output logic          branch_done,
  output logic          ret_done
);

  seq_state_t    state;
  logic [AW-1:0] ptr_ea;
  logic [HW-1:0] hi_q;
  logic [AW-1:0] vec_tgt;
  logic          vec_take;
  logic          hi_take;
  logic          lo_take;

  assign idle     = (state == S_IDLE);
  assign pop      = idle && ret_en;
  assign accept   = idle && !ret_en && instr_done && irq_req && !inhibit;
  assign vec_tgt  = rel_zero(dbus_in[DW-2:0]);
  assign vec_take = (state == S_VEC)    && op_ack;
  assign hi_take  = (state == S_PTR_HI) && op_ack;
  assign lo_take  = (state == S_PTR_LO) && op_ack;

  assign op_req   = !idle;
  assign int_ack  = (state == S_VEC);
  assign ptr_rd   = (state == S_PTR_HI) || (state == S_PTR_LO);
  assign mem_addr = (state == S_PTR_LO) ? addr_next(ptr_ea) : ptr_ea;

  always_ff @(posedge clk) begin
    if (!rst_n)                 inhibit <= 1'b0;
    else if (accept)            inhibit <= 1'b1;
    else if (pop)               inhibit <= 1'b0;
    else if (idle && inh_clr)   inhibit <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      ptr_ea      <= '0;
      hi_q        <= '0;
      next_pc     <= '0;
      branch_done <= 1'b0;
      ret_done    <= 1'b0;
    end else begin
      branch_done <= 1'b0;
      ret_done    <= 1'b0;
      case (state)
        S_IDLE: begin
          if (pop) begin
            next_pc  <= ret_data;
            ret_done <= 1'b1;
          end else if (accept) begin
            state <= S_VEC;
          end
        end
        S_VEC: begin
          if (vec_take) begin
            if (dbus_in[DW-1]) begin
              ptr_ea <= vec_tgt;
              state  <= S_PTR_HI;
            end else begin
              next_pc     <= vec_tgt;
              branch_done <= 1'b1;
              state       <= S_IDLE;
            end
          end
        end
        S_PTR_HI: begin
          if (hi_take) begin
            hi_q  <= dbus_in[HW-1:0];
            state <= S_PTR_LO;
          end
        end
        S_PTR_LO: begin
          if (lo_take) begin
            next_pc     <= {hi_q, dbus_in};
            branch_done <= 1'b1;
            state       <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_ack_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> op_req);
  p_accept_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> inhibit && int_ack);
  p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && op_ack |=> !int_ack);
  p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && !op_ack |=> int_ack);
  p_ret_enables_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !inhibit && ret_done && !op_req);
  p_ptr_no_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rd |-> op_req && !int_ack);
  p_done_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    branch_done |=> !branch_done);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irqseq_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DW    = BYTE_W,
  parameter int DEPTH = STK_DEP,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_done,
  input  logic          irq_req,
  input  logic [AW-1:0] ret_addr_in,
  input  logic          ret_en,
  input  logic          inh_clr,
  input  logic [DW-1:0] dbus_in,
  input  logic          op_ack,
  output logic          op_req,
  output logic          int_ack,
  output logic          ptr_rd,
  output logic [AW-1:0] mem_addr,
  output logic          inhibit,
  output logic [PW-1:0] stk_ptr,
  output logic [AW-1:0] next_pc,
  output logic          branch_done,
  output logic          ret_done
);

  logic          ev_accept;
  logic          ev_pop;
  logic          ev_idle;
  logic [AW-1:0] stk_top;

  ret_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ev_accept),
    .pop      (ev_pop),
    .wr_data  (ret_addr_in),
    .sp       (stk_ptr),
    .top_data (stk_top)
  );

  entry_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_done  (instr_done),
    .irq_req     (irq_req),
    .ret_en      (ret_en),
    .inh_clr     (inh_clr),
    .dbus_in     (dbus_in),
    .op_ack      (op_ack),
    .ret_data    (stk_top),
    .accept      (ev_accept),
    .pop         (ev_pop),
    .idle        (ev_idle),
    .inhibit     (inhibit),
    .op_req      (op_req),
    .int_ack     (int_ack),
    .ptr_rd      (ptr_rd),
    .mem_addr    (mem_addr),
    .next_pc     (next_pc),
    .branch_done (branch_done),
    .ret_done    (ret_done)
  );

  p_inh_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit && !ev_pop |=> stk_ptr == $past(stk_ptr));
  p_sp_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_idle |=> $stable(stk_ptr));
  p_inh_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_idle |=> inhibit);

endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_done = 1'b0, irq_req = 1'b0, ret_en = 1'b0, inh_clr = 1'b0, op_ack = 1'b0;
  logic [14:0] ret_addr_in = '0;
  logic [7:0]  dbus_in = '0;
  logic        op_req, int_ack, ptr_rd, inhibit, branch_done, ret_done;
  logic [14:0] mem_addr, next_pc;
  logic [2:0]  stk_ptr;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [2:0]  m_sp = '0;
  logic [14:0] m_stk [8];
  logic        m_inh = 1'b0;

  always #10 clk = ~clk;

  irq_entry_seq u0 (.*);

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int disp_addr(logic [7:0] v);
    int d = int'(v & 8'h7F);
    if (d >= 64) d = d - 128;
    return (d + 32768) % 32768;
  endfunction

  task automatic wait_noise(int n);
    for (int k = 0; k < n; k++) begin
      ret_en  = ($urandom % 3) == 0;
      inh_clr = ($urandom % 3) == 0;
      instr_done = ($urandom % 2) == 0;
      irq_req = 1'b1;
      @(negedge clk);
      chk("R4 ack held", int_ack, 1'b1);
    end
    ret_en = 0; inh_clr = 0; instr_done = 0; irq_req = 0;
  endtask

  task automatic mem_ack(logic [7:0] b, int n);
    for (int k = 0; k < n; k++) begin
      ret_en = ($urandom % 2) == 0;
      @(negedge clk);
    end
    ret_en = 0;
    dbus_in = b; op_ack = 1;
    @(negedge clk);
    op_ack = 0;
  endtask

  task automatic try_entry(bit irq, bit done, logic [14:0] ra, logic [7:0] v);
    bit take;
    int ea, tgt;
    logic [7:0] hi, lo;
    take = irq && done && !m_inh;
    instr_done = done; irq_req = irq; ret_addr_in = ra;
    @(negedge clk);
    instr_done = 0; irq_req = 0;
    if (!take) begin
      chk("R2 no ack", int_ack, 0);
      chk("R2 sp kept", stk_ptr, m_sp);
      chk("R2 inhibit kept", inhibit, m_inh);
      return;
    end
    m_sp = m_sp + 1; m_stk[m_sp] = ra; m_inh = 1;
    chk("R3 ack", int_ack, 1);
    chk("R3 req", op_req, 1);
    chk("R3 inhibit", inhibit, 1);
    chk("R7 sp push", stk_ptr, m_sp);
    wait_noise($urandom % 4);
    dbus_in = v; op_ack = 1;
    @(negedge clk);
    op_ack = 0;
    chk("R4 ack drop", int_ack, 0);
    if (!v[7]) begin
      tgt = disp_addr(v);
      chk("R5 target", next_pc, tgt);
      chk("R5 done", branch_done, 1);
      chk("R5 req low", op_req, 0);
    end else begin
      ea = disp_addr(v);
      chk("R6 ptr rd", ptr_rd, 1);
      chk("R6 addr hi", mem_addr, ea);
      hi = 8'($urandom); lo = 8'($urandom);
      mem_ack(hi, $urandom % 3);
      chk("R6 addr lo", mem_addr, (ea + 1) % 32768);
      chk("R6 ack low", int_ack, 0);
      mem_ack(lo, $urandom % 3);
      tgt = int'(hi & 8'h7F) * 256 + int'(lo);
      chk("R6 target", next_pc, tgt);
      chk("R6 done", branch_done, 1);
    end
    chk("R10 inhibit kept", inhibit, 1);
    chk("R10 sp kept", stk_ptr, m_sp);
  endtask

  task automatic do_ret(bit with_irq);
    ret_en = 1; instr_done = with_irq; irq_req = with_irq;
    @(negedge clk);
    ret_en = 0; instr_done = 0; irq_req = 0;
    chk("R8 pc", next_pc, m_stk[m_sp]);
    m_sp = m_sp - 1; m_inh = 0;
    chk("R8 sp", stk_ptr, m_sp);
    chk("R8 inhibit", inhibit, 0);
    chk("R8 done", ret_done, 1);
    chk("R8 precedence", int_ack, 0);
  endtask

  task automatic do_clr();
    inh_clr = 1;
    @(negedge clk);
    inh_clr = 0;
    m_inh = 0;
    chk("R9 inhibit", inhibit, 0);
    chk("R9 sp", stk_ptr, m_sp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7215));
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 sp", stk_ptr, 0);
    chk("R1 inhibit", inhibit, 0);
    chk("R1 pc", next_pc, 0);
    chk("R1 req", op_req, 0);
    chk("R1 ack", int_ack, 0);

    // Directed vectors
    try_entry(1, 0, 15'h1234, 8'h10);        // R2: no boundary
    try_entry(1, 1, 15'h1234, 8'h7F);        // R5: -1 -> 0x7FFF
    try_entry(1, 1, 15'h0055, 8'h01);        // R2: inhibited
    do_ret(1);                               // R8: irq waits
    try_entry(1, 1, 15'h0202, 8'h3F);        // R5: 0x003F
    do_ret(0);
    try_entry(1, 1, 15'h0303, 8'hC0);        // R6: EA 0x7FC0
    do_ret(0);
    try_entry(1, 1, 15'h0404, 8'hFF);        // R6: EA 0x7FFF, wraps to 0
    do_ret(0);

    // R7 wrap: nine nested entries, then nine returns
    for (int i = 0; i < 9; i++) begin
      try_entry(1, 1, 15'(16'h0100 + i), 8'(i));
      do_clr();
    end
    for (int i = 0; i < 9; i++) do_ret(0);

    // Random rounds
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 5)
        0, 1: try_entry(($urandom % 4) != 0, ($urandom % 4) != 0, 15'($urandom), 8'($urandom));
        2:    do_ret(($urandom % 2) == 0);
        3:    do_clr();
        default: try_entry(1, 1, 15'($urandom), 8'($urandom));
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule